// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block drives an asynchronous DRAM whose row and column addresses share one 10-bit bus and whose cycles are framed by active-low row strobe, column strobe, write enable and output enable pins. On the host side it takes single-word requests over a valid/ready port: a 20-bit word address, a write flag and 4 bits of write data. A read returns its word as a one-cycle response pulse. The response has no back-pressure, so the host must always be able to take it. A request is taken only on a clock edge where both `req_valid` and `req_ready` are high. While `req_valid` is high the host keeps address, write flag and data steady. The block lowers `req_ready` whenever it is busy or a refresh is pending.

Once an access finishes, the row stays open. A later request to the same row then needs only a column strobe pulse. A request to another row first precharges and then opens the new row. A free-running interval timer requests a refresh in which the column strobe falls before the row strobe. In that cycle the memory takes the row from its own internal counter. A pending refresh wins over new host requests, and an open row is closed before the refresh starts. Every strobe edge waits a parameterised minimum number of clock cycles.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: Host address bits [19:10] are the row and bits [9:0] the column. The row is on `dram_addr` at least one cycle before the row strobe falls. The column is on `dram_addr` at least one cycle before the column strobe falls. Each is held on the edge where its strobe falls.
- R2: Read latency is counted in clock edges from the accepting edge to the edge that raises `rsp_valid`. It is 1+T_CAS for an open-row hit, 2+T_RCD+T_CAS when no row is open, and T_RP+2+T_RCD+T_CAS for a different row. `rsp_rdata` holds the word sampled from `dram_dq_i` at the end of the column pulse.
- R3: An access to the row that is already open does not pulse the row strobe. Any other access opens its row exactly once.
- R4: The row strobe stays high for at least T_RP cycles before each fall.
- R5: For an access, the row strobe has been low at least T_RCD cycles when the column strobe falls.
- R6: During an access the column strobe stays low at least T_CAS cycles. Before each fall it is high at least T_CP cycles.
- R7: On writes, write enable is low and the data drivers (`dram_dq_oe`=1) are on at least one cycle before the column strobe falls. Output enable stays high while the column strobe is low.
- R8: On reads, output enable is low and write enable is high while the column strobe is low.
- R9: A refresh lowers the column strobe while the row strobe is high, then lowers the row strobe, then raises both together. Write enable stays high and no address is used.
- R10: Refresh requests come every REF_PERIOD = CLK_KHZ*RETAIN_MS/2^MA_W - REF_MARGIN cycles. Each is served within a bounded delay, so every row is refreshed within the retention time.
- R11: While a refresh is pending `req_ready` is low. An open row is closed, with its precharge, before the refresh. The next access finds no row open.
- R12: `rsp_valid` is a single-cycle pulse, one for each read and none for writes.
- R13: After reset, and after a reset that arrives in the middle of an access, all strobes are high, the data drivers are off, no row is open and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*MA_W | Word address, row in upper half |
| req_wdata | input | DQ_W | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DQ_W | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | MA_W | Multiplexed row/column address |
| dram_dq_o | output | DQ_W | Data driven to the memory |
| dram_dq_oe | output | 1 | Data driver enable |
| dram_dq_i | input | DQ_W | Data returned from the memory |

## Verification
A read's response is due a fixed number of edges after the accepting edge. That number depends on whether the row was open, closed or different (R2). The bench works out which case applies from its own record of the last row used and of any refresh seen since. It drives inputs and samples outputs on falling edges and counts rising edges from acceptance until `rsp_valid` appears, then compares that count with the formula. A behavioural memory model in the bench records strobe edges one cycle after they happen. It counts row openings, precharge time, CBR order and refresh spacing, and these totals are checked after each access and at the end of a long idle stretch.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,   // waiting; row may be open
    ST_PRE,    // row strobe high, precharge count
    ST_RAS,    // row address settled, drop row strobe
    ST_RCD,    // row-to-column wait
    ST_COL,    // column address settled, drop column strobe
    ST_CAS,    // column pulse
    ST_CP,     // column precharge
    ST_RCAS,   // refresh: column strobe low, row strobe high
    ST_RRAS    // refresh: both strobes low
  } fpm_state_e;
endpackage

// File: rtl/fpm_ref_timer.sv
module fpm_ref_timer #(
  parameter int PERIOD = 3842
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pend
);
  localparam int TW = $clog2(PERIOD + 1);
  logic [TW-1:0] tcnt;
  logic          tick;

  assign tick = (tcnt == TW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      pend <= 1'b0;
    end else begin
      tcnt <= tick ? '0 : tcnt + 1'b1;
      if (tick)     pend <= 1'b1;
      else if (ack) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/fpm_row_match.sv
module fpm_row_match #(
  parameter int MA_W = 10
) (
  input  logic [2*MA_W-1:0] req_addr,
  input  logic              page_open,
  input  logic [MA_W-1:0]   open_row,
  output logic [MA_W-1:0]   row,
  output logic [MA_W-1:0]   col,
  output logic              hit
);
  assign row = req_addr[2*MA_W-1:MA_W];
  assign col = req_addr[MA_W-1:0];
  assign hit = page_open && (row == open_row);
endmodule

// File: rtl/fpm_strobe_seq.sv
module fpm_strobe_seq
  import fpm_pkg::*;
#(
  parameter int MA_W      = 10,
  parameter int DQ_W      = 4,
  parameter int T_RP      = 2,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 3,
  parameter int T_CP      = 1,
  parameter int T_CSR     = 1,
  parameter int T_RAS_REF = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [DQ_W-1:0] req_wdata,
  input  logic [MA_W-1:0] row_in,
  input  logic [MA_W-1:0] col_in,
  input  logic            hit,
  output logic            req_ready,
  input  logic            ref_pend,
  output logic            ref_ack,
  output logic            page_open,
  output logic [MA_W-1:0] open_row,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic            oe_n,
  output logic [MA_W-1:0] addr,
  output logic [DQ_W-1:0] dq_o,
  output logic            dq_oe,
  input  logic [DQ_W-1:0] dq_i,
  output logic            rsp_valid,
  output logic [DQ_W-1:0] rsp_rdata
);
  localparam int CW = $clog2(T_RP + T_RCD + T_CAS + T_CP + T_CSR + T_RAS_REF + 1);

  fpm_state_e      state;
  logic [CW-1:0]   cnt;
  logic [MA_W-1:0] lrow, lcol;
  logic            lwr, go_row;

  assign req_ready = (state == ST_IDLE) && !ref_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      addr      <= '0;
      dq_o      <= '0;
      dq_oe     <= 1'b0;
      page_open <= 1'b0;
      open_row  <= '0;
      lrow      <= '0;
      lcol      <= '0;
      lwr       <= 1'b0;
      go_row    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      ref_ack   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      ref_ack   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ref_pend) begin
            if (page_open) begin
              ras_n     <= 1'b1;
              page_open <= 1'b0;
              go_row    <= 1'b0;
              cnt       <= CW'(T_RP - 1);
              state     <= ST_PRE;
            end else begin
              cas_n <= 1'b0;
              cnt   <= CW'(T_CSR - 1);
              state <= ST_RCAS;
            end
          end else if (req_valid) begin
            lrow <= row_in;
            lcol <= col_in;
            lwr  <= req_write;
            dq_o <= req_wdata;
            if (hit) begin
              addr  <= col_in;
              we_n  <= !req_write;
              dq_oe <= req_write;
              state <= ST_COL;
            end else if (page_open) begin
              ras_n     <= 1'b1;
              page_open <= 1'b0;
              go_row    <= 1'b1;
              cnt       <= CW'(T_RP - 1);
              state     <= ST_PRE;
            end else begin
              addr  <= row_in;
              state <= ST_RAS;
            end
          end
        end
        ST_PRE: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (go_row) begin
            addr  <= lrow;
            state <= ST_RAS;
          end else state <= ST_IDLE;
        end
        ST_RAS: begin
          ras_n <= 1'b0;
          cnt   <= CW'(T_RCD - 1);
          state <= ST_RCD;
        end
        ST_RCD: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            addr  <= lcol;
            we_n  <= !lwr;
            dq_oe <= lwr;
            state <= ST_COL;
          end
        end
        ST_COL: begin
          cas_n <= 1'b0;
          oe_n  <= lwr;
          cnt   <= CW'(T_CAS - 1);
          state <= ST_CAS;
        end
        ST_CAS: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            cas_n     <= 1'b1;
            oe_n      <= 1'b1;
            we_n      <= 1'b1;
            dq_oe     <= 1'b0;
            page_open <= 1'b1;
            open_row  <= lrow;
            rsp_valid <= !lwr;
            if (!lwr) rsp_rdata <= dq_i;
            cnt       <= CW'(T_CP - 1);
            state     <= ST_CP;
          end
        end
        ST_CP: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else state <= ST_IDLE;
        end
        ST_RCAS: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            ras_n   <= 1'b0;
            ref_ack <= 1'b1;
            cnt     <= CW'(T_RAS_REF - 1);
            state   <= ST_RRAS;
          end
        end
        ST_RRAS: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            ras_n  <= 1'b1;
            cas_n  <= 1'b1;
            go_row <= 1'b0;
            cnt    <= CW'(T_RP - 1);
            state  <= ST_PRE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int MA_W       = 10,
  parameter int DQ_W       = 4,
  parameter int T_RP       = 2,
  parameter int T_RCD      = 2,
  parameter int T_CAS      = 3,
  parameter int T_CP       = 1,
  parameter int T_CSR      = 1,
  parameter int T_RAS_REF  = 4,
  parameter int CLK_KHZ    = 250000,
  parameter int RETAIN_MS  = 16,
  parameter int REF_MARGIN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [2*MA_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              rsp_valid,
  output logic [DQ_W-1:0]   rsp_rdata,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [MA_W-1:0]   dram_addr,
  output logic [DQ_W-1:0]   dram_dq_o,
  output logic              dram_dq_oe,
  input  logic [DQ_W-1:0]   dram_dq_i
);
  localparam int ROWS       = 1 << MA_W;
  localparam int REF_PERIOD = CLK_KHZ * RETAIN_MS / ROWS - REF_MARGIN;

  logic            ref_pend, ref_ack, page_open, hit;
  logic [MA_W-1:0] open_row, row_w, col_w;

  fpm_ref_timer #(.PERIOD(REF_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pend(ref_pend)
  );

  fpm_row_match #(.MA_W(MA_W)) u_match (
    .req_addr(req_addr), .page_open(page_open), .open_row(open_row),
    .row(row_w), .col(col_w), .hit(hit)
  );

  fpm_strobe_seq #(
    .MA_W(MA_W), .DQ_W(DQ_W), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_CP(T_CP), .T_CSR(T_CSR), .T_RAS_REF(T_RAS_REF)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
    .row_in(row_w), .col_in(col_w), .hit(hit), .req_ready(req_ready),
    .ref_pend(ref_pend), .ref_ack(ref_ack),
    .page_open(page_open), .open_row(open_row),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
    .addr(dram_addr), .dq_o(dram_dq_o), .dq_oe(dram_dq_oe), .dq_i(dram_dq_i),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/fpm_dram_chk.sv
module fpm_dram_chk #(
  parameter int MA_W  = 10,
  parameter int T_RP  = 2,
  parameter int T_RCD = 2,
  parameter int T_CAS = 3,
  parameter int T_CP  = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic            oe_n,
  input logic [MA_W-1:0] addr,
  input logic            dq_oe,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            ref_pend,
  input logic            ref_ack
);
  // Saturating run-length counters; reset to the top so the device counts as precharged.
  logic [7:0] ras_hi, ras_lo, cas_hi, cas_lo;
  logic       in_cbr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_hi <= 8'hFF; ras_lo <= '0; cas_hi <= 8'hFF; cas_lo <= '0; in_cbr <= 1'b0;
    end else begin
      ras_hi <= ras_n  ? ((ras_hi == 8'hFF) ? ras_hi : ras_hi + 1'b1) : '0;
      ras_lo <= !ras_n ? ((ras_lo == 8'hFF) ? ras_lo : ras_lo + 1'b1) : '0;
      cas_hi <= cas_n  ? ((cas_hi == 8'hFF) ? cas_hi : cas_hi + 1'b1) : '0;
      cas_lo <= !cas_n ? ((cas_lo == 8'hFF) ? cas_lo : cas_lo + 1'b1) : '0;
      if (cas_n) in_cbr <= 1'b0;
      else if (ras_n) in_cbr <= 1'b1;
    end
  end

  a_r1_row_held: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) && cas_n |-> $stable(addr));
  a_r1_col_held: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && !ras_n |-> $stable(addr));
  a_r4_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ras_hi >= 8'(T_RP));
  a_r5_row_to_col: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && !ras_n |-> ras_lo >= 8'(T_RCD));
  a_r6_cas_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) && !ras_n |-> cas_lo >= 8'(T_CAS));
  a_r6_cas_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> cas_hi >= 8'(T_CP));
  a_r7_we_early: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && !ras_n |-> $stable(we_n));
  a_r7_write_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n && !ras_n && !we_n |-> dq_oe && oe_n);
  a_r8_read_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n && !ras_n && we_n && !in_cbr |-> !oe_n);
  a_r9_cbr_form: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) && !cas_n |-> we_n && oe_n && !dq_oe);
  a_r10_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend && !ref_ack |=> ref_pend);
  a_r11_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !req_ready);
  a_r11_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cas_n);
  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind fpm_dram_ctrl fpm_dram_chk #(
  .MA_W(MA_W), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .oe_n(dram_oe_n), .addr(dram_addr), .dq_oe(dram_dq_oe),
  .req_ready(req_ready), .rsp_valid(rsp_valid),
  .ref_pend(ref_pend), .ref_ack(ref_ack)
);

// File: tb/sim_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module sim_fpm_dram_ctrl;
  localparam int MA_W = 10, DQ_W = 4;
  localparam int T_RP = 2, T_RCD = 2, T_CAS = 3, T_CP = 1, T_CSR = 1, T_RAS_REF = 4;
  localparam int CLK_KHZ = 4000, RETAIN_MS = 16, REF_MARGIN = 0;
  localparam int ROWS = 1 << MA_W;
  localparam int REF = CLK_KHZ * RETAIN_MS / ROWS - REF_MARGIN;
  localparam int LAT_HIT = 1 + T_CAS;
  localparam int LAT_CLOSED = 2 + T_RCD + T_CAS;
  localparam int LAT_MISS = T_RP + 2 + T_RCD + T_CAS;

  // {write, row, col, data}
  localparam logic [24:0] VEC [16] = '{
    {1'b1, 10'h155, 10'h001, 4'h5}, {1'b1, 10'h155, 10'h002, 4'hA},
    {1'b1, 10'h155, 10'h3FF, 4'hF}, {1'b0, 10'h155, 10'h001, 4'h0},
    {1'b0, 10'h155, 10'h002, 4'h0}, {1'b1, 10'h2AA, 10'h010, 4'h3},
    {1'b0, 10'h155, 10'h3FF, 4'h0}, {1'b0, 10'h2AA, 10'h010, 4'h0},
    {1'b1, 10'h3FF, 10'h3FF, 4'hC}, {1'b0, 10'h3FF, 10'h3FF, 4'h0},
    {1'b1, 10'h000, 10'h000, 4'h7}, {1'b0, 10'h000, 10'h000, 4'h0},
    {1'b0, 10'h155, 10'h000, 4'h0}, {1'b1, 10'h155, 10'h000, 4'h9},
    {1'b0, 10'h155, 10'h000, 4'h0}, {1'b0, 10'h3FF, 10'h3FF, 4'h0}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, rsp_valid;
  logic [2*MA_W-1:0] req_addr;
  logic [DQ_W-1:0] req_wdata, rsp_rdata, dq_o, dq_i;
  logic ras, cas, we, oe, dq_oe;
  logic [MA_W-1:0] addr;

  fpm_dram_ctrl #(
    .MA_W(MA_W), .DQ_W(DQ_W), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_CP(T_CP), .T_CSR(T_CSR), .T_RAS_REF(T_RAS_REF),
    .CLK_KHZ(CLK_KHZ), .RETAIN_MS(RETAIN_MS), .REF_MARGIN(REF_MARGIN)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dram_ras_n(ras), .dram_cas_n(cas), .dram_we_n(we), .dram_oe_n(oe),
    .dram_addr(addr), .dram_dq_o(dq_o), .dram_dq_oe(dq_oe), .dram_dq_i(dq_i)
  );

  int checks = 0, fails = 0;
  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  int cyc = 0, ref_cnt = 0, act_cnt = 0, ref_ctr = 0;
  int last_ref = 0, max_gap = 0, min_gap = 1 << 30;
  int v_order = 0, v_pre = 0, v_early = 0, v_ready = 0;
  int ras_hi = 1000, m_row = 0, m_col = 0;
  bit cbr_armed = 1'b0;
  bit [ROWS-1:0] covered = '0;
  logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1;
  logic [DQ_W-1:0] dmem [int];

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      prev_ras = 1'b1; prev_cas = 1'b1; prev_we = 1'b1;
      ras_hi = 1000; cbr_armed = 1'b0; dq_i = '0; last_ref = cyc;
    end else begin
      if (prev_ras && !ras) begin
        if (ras_hi < T_RP + 1) v_pre++;
        if (!cas) begin
          if (!cbr_armed || !we) v_order++;
          cbr_armed = 1'b0;
          covered[ref_ctr] = 1'b1;
          ref_ctr = (ref_ctr + 1) % ROWS;
          if (cyc - last_ref > max_gap) max_gap = cyc - last_ref;
          if (ref_cnt > 0 && cyc - last_ref < min_gap) min_gap = cyc - last_ref;
          last_ref = cyc;
          ref_cnt++;
        end else begin
          m_row = int'(addr);
          act_cnt++;
        end
      end
      if (prev_cas && !cas) begin
        if (ras) begin
          cbr_armed = 1'b1;
          if (ras_hi < T_RP + 1 || !we) v_order++;
        end else begin
          m_col = int'(addr);
          if (!we) begin
            if (prev_we || !dq_oe) v_early++;
            dmem[m_row * ROWS + m_col] = dq_o;
          end
        end
      end
      if (!prev_cas && cas) begin
        if (cbr_armed) v_order++;
        cbr_armed = 1'b0;
      end
      if (req_ready && !cas) v_ready++;
      ras_hi = ras ? ras_hi + 1 : 0;
      if (!ras && !cas && !oe && we && dmem.exists(m_row * ROWS + m_col))
        dq_i = dmem[m_row * ROWS + m_col];
      else dq_i = '0;
      prev_ras = ras; prev_cas = cas; prev_we = we;
    end
  end

  // ---------------- host side ----------------
  logic [DQ_W-1:0] exp_mem [int];
  bit   b_open = 1'b0;
  int   b_row = 0, b_refs = 0;

  task automatic access(input bit wr, input int row, input int col, input logic [DQ_W-1:0] d,
                        output int lat, output logic [DQ_W-1:0] rd);
    int acts0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    req_addr = (2*MA_W)'(row * ROWS + col); req_wdata = d;
    for (int w = 0; w < 400 && !req_ready; w++) @(negedge clk);
    acts0 = act_cnt;
    if (ref_cnt != b_refs) b_open = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0; rd = '0;
    if (!wr) begin
      for (int w = 0; w < 100 && !rsp_valid; w++) begin @(negedge clk); lat++; end
      rd = rsp_rdata;
      @(negedge clk);
      check(!rsp_valid, "R12 pulse width", int'(rsp_valid), 0);
    end else begin
      for (int w = 0; w < 100 && cas; w++) @(negedge clk);
      for (int w = 0; w < 100 && !cas; w++) @(negedge clk);
      check(!rsp_valid, "R12 no write response", int'(rsp_valid), 0);
    end
    check(m_row == row, "R1 row on bus", m_row, row);
    check(m_col == col, "R1 column on bus", m_col, col);
    if (b_open && b_row == row)
      check(act_cnt == acts0, "R3 hit keeps row open", act_cnt - acts0, 0);
    else
      check(act_cnt == acts0 + 1, "R3 new row opened once", act_cnt - acts0, 1);
    b_refs = ref_cnt;
  endtask

  function automatic int exp_lat(input int row);
    if (!b_open) return LAT_CLOSED;
    return (b_row == row) ? LAT_HIT : LAT_MISS;
  endfunction

  task automatic run_vec(input bit wr, input int row, input int col, input logic [DQ_W-1:0] d);
    int lat, want;
    logic [DQ_W-1:0] rd, expd;
    access(wr, row, col, d, lat, rd);
    // b_open was refreshed inside access() for refreshes seen before acceptance
    want = exp_lat(row);
    if (wr) exp_mem[row * ROWS + col] = d;
    else begin
      expd = exp_mem.exists(row * ROWS + col) ? exp_mem[row * ROWS + col] : '0;
      check(lat == want, "R2 read latency", lat, want);
      check(rd == expd, "R2 read data", int'(rd), int'(expd));
    end
    b_open = 1'b1; b_row = row;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lat;
    logic [DQ_W-1:0] rd;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R13 reset state
    check(ras && cas && we && oe, "R13 strobes high in reset", {ras, cas, we, oe}, 15);
    check(!dq_oe, "R13 drivers off in reset", int'(dq_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R13 ready after reset", int'(req_ready), 1);
    check(!rsp_valid, "R12 no response after reset", int'(rsp_valid), 0);
    b_refs = ref_cnt;

    foreach (VEC[i])
      run_vec(VEC[i][24], int'(VEC[i][23:14]), int'(VEC[i][13:4]), VEC[i][3:0]);

    // R11: refresh closes the open row, so the same row reads as a closed access
    run_vec(1'b0, 'h2AA, 'h010, '0);
    for (int w = 0; w < 3 * REF && ref_cnt == b_refs; w++) @(negedge clk);
    check(ref_cnt > b_refs, "R11 refresh arrived", ref_cnt - b_refs, 1);
    access(1'b0, 'h2AA, 'h010, '0, lat, rd);
    check(lat == LAT_CLOSED, "R11 row closed by refresh", lat, LAT_CLOSED);
    check(rd == 4'h3, "R11 data kept across refresh", int'(rd), 3);
    b_open = 1'b1; b_row = 'h2AA;

    // R13: reset in the middle of a column pulse
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h00123;
    for (int w = 0; w < 400 && !req_ready; w++) @(negedge clk);
    @(negedge clk); req_valid = 1'b0;
    for (int w = 0; w < 40 && cas; w++) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(ras && cas && we && oe && !dq_oe, "R13 mid-access reset", {ras, cas, we, oe, dq_oe}, 30);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R13 ready after mid reset", int'(req_ready), 1);
    b_open = 1'b0; b_refs = ref_cnt;
    run_vec(1'b0, 'h3FF, 'h3FF, '0);

    // R10: idle long enough for the internal counter to wrap
    for (int w = 0; w < (ROWS + 8) * (REF + 40) && ref_cnt < ROWS + 4; w++) @(negedge clk);
    check(&covered, "R10 every row refreshed", $countones(covered), ROWS);
    check(max_gap <= REF + 32, "R10 longest refresh gap", max_gap, REF + 32);
    check(min_gap >= REF - 32, "R10 shortest refresh gap", min_gap, REF - 32);
    check(v_order == 0, "R9 refresh strobe order", v_order, 0);
    check(v_pre == 0, "R4 row precharge", v_pre, 0);
    check(v_early == 0, "R7 early write setup", v_early, 0);
    check(v_ready == 0, "R11 ready during column strobe", v_ready, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule